// File: doc/BRIEF.md
# Transmit Frame Pad and FCS Appender

The block sits between a host transmit buffer and the MAC serializer. For each frame the host issues a command with a byte length and two flags, pad enable and FCS inhibit, then streams the frame bytes. The block checks the length first and drops any command whose length is out of range. For a legal command it forwards the bytes. When padding is on, it adds zero bytes to bring a short frame up to the minimum data size. Unless the FCS is inhibited, it then appends the 4-byte CRC-32.

The block can end a frame early. If the host stops supplying bytes while the serializer is asking for data, that is an underrun. If a collision arrives after the collision window, that is a late collision. In both cases the block stops the data, sends a deliberately wrong FCS and closes the frame. One status pulse per command reports how the frame ended.

Top module: `tx_fcs_framer`

## Requirements
- R1: A command with length below 3 or above 1518 is accepted but sends nothing. The block consumes no input byte for it. `sts_len_err_o` pulses for one cycle, in the cycle after the command handshake.
- R2: A command with length from 3 to 1518 inclusive passes exactly that many input bytes to the output, in order and unchanged.
- R3: With pad enabled and a length below 60, zero bytes follow the data until 60 data-plus-pad bytes have been sent.
- R4: With pad disabled, no zero bytes are added, whatever the length.
- R5: Padding to 60 bytes still happens when FCS generation is inhibited.
- R6: Unless inhibited, 4 FCS bytes follow the data and pad. The FCS is CRC-32: reflected polynomial 0xEDB88320, initial value all ones, final inversion, computed over the data and pad bytes. It is sent least significant byte first. With FCS inhibited, no FCS bytes are sent on a normal frame.
- R7: `out_last_o` is high on the final byte of each frame and on no other byte.
- R8: During the data phase, an underrun is a cycle where `out_ready_i` is high and `in_valid_i` is low. On an underrun the data stops and 4 bytes follow: the bitwise complement of the correct FCS over the bytes already sent. This happens even when the FCS is inhibited. `sts_underrun_o` pulses.
- R9: `late_col_i` high during the data or pad phase ends that phase at once. No byte is transferred in that cycle. The same 4 complemented FCS bytes follow, and `sts_late_col_o` pulses.
- R10: Exactly one of `sts_ok_o`, `sts_underrun_o` or `sts_late_col_o` pulses for one cycle, in the cycle after the handshake of a frame's last byte. `sts_ok_o` marks a frame that ended normally.
- R11: After reset, `cmd_ready_o` is high, and `out_valid_o`, `in_ready_o` and all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Frame command valid |
| cmd_ready_o | output | 1 | Block idle, command taken |
| cmd_len_i | input | 11 | Frame length in bytes |
| cmd_pad_en_i | input | 1 | Pad short frames to 60 bytes |
| cmd_crc_inh_i | input | 1 | Do not append FCS |
| in_valid_i | input | 1 | Host byte valid |
| in_ready_o | output | 1 | Host byte taken |
| in_data_i | input | 8 | Host byte |
| late_col_i | input | 1 | Collision after the collision window |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Serializer takes byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of frame |
| sts_ok_o | output | 1 | Frame ended normally |
| sts_len_err_o | output | 1 | Command length rejected |
| sts_underrun_o | output | 1 | Frame ended by underrun |
| sts_late_col_o | output | 1 | Frame ended by late collision |

## Verification
A byte counter that drifts shows up within one frame. Pad bytes come out short or long, or `out_last_o` lands on the wrong byte, and every later byte of the frame is then off. A CRC register that is not re-seeded, or updated on a stalled cycle, corrupts every FCS byte of that frame. An abort path that keeps the wrong flag shows in the very next status pulse. A stuck phase shows as a frame with no end status before the next command.

// File: rtl/tx_fcs_pkg.sv
package tx_fcs_pkg;
  localparam int unsigned FCS_BYTES = 4;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAD, ST_FCS} tx_st_e;
  typedef enum logic [1:0] {SEL_DATA, SEL_ZERO, SEL_FCS} out_sel_e;

  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/tx_len_check.sv
module tx_len_check #(
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned MIN_LEN = 3,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned PAD_MIN = 60
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             pad_en_i,
  output logic             legal_o,
  output logic             pad_need_o
);
  localparam logic [LEN_W-1:0] LoLim  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HiLim  = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] PadLim = LEN_W'(PAD_MIN);

  assign legal_o    = (len_i >= LoLim) && (len_i <= HiLim);
  assign pad_need_o = pad_en_i && (len_i < PadLim);
endmodule

// File: rtl/tx_crc32.sv
module tx_crc32
  import tx_fcs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (init_i) crc_q <= CRC_SEED;
    else if (en_i)   crc_q <= crc32_step(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/tx_out_mux.sv
module tx_out_mux
  import tx_fcs_pkg::*;
(
  input  out_sel_e    sel_i,
  input  logic [7:0]  in_data_i,
  input  logic [31:0] crc_i,
  input  logic [1:0]  idx_i,
  input  logic        bad_i,
  output logic [7:0]  data_o
);
  logic [7:0] fcs_b [FCS_BYTES];
  logic [7:0] fcs_sel;

  for (genvar g = 0; g < int'(FCS_BYTES); g++) begin : g_fcs
    // good FCS is the inverted register; a forced bad one is its complement
    assign fcs_b[g] = bad_i ? crc_i[8*g +: 8] : ~crc_i[8*g +: 8];
  end

  assign fcs_sel = fcs_b[idx_i];

  always_comb begin
    unique case (sel_i)
      SEL_ZERO: data_o = 8'h00;
      SEL_FCS:  data_o = fcs_sel;
      default:  data_o = in_data_i;
    endcase
  end
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_fcs_pkg::*;
#(
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned PAD_MIN = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             cmd_crc_inh_i,
  input  logic             legal_i,
  input  logic             pad_need_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             late_col_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_last_o,
  output out_sel_e         out_sel_o,
  output logic [1:0]       fcs_idx_o,
  output logic             fcs_bad_o,
  output logic             crc_init_o,
  output logic             crc_en_o,
  output logic             sts_ok_o,
  output logic             sts_len_err_o,
  output logic             sts_underrun_o,
  output logic             sts_late_col_o
);
  localparam logic [LEN_W-1:0] PadEnd  = LEN_W'(PAD_MIN - 1);
  localparam logic [1:0]       FcsEnd  = 2'(FCS_BYTES - 1);

  tx_st_e           state_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             pad_need_q, crc_inh_q;
  logic [1:0]       fidx_q;
  logic             abort_q, late_q;
  logic             ok_q, len_err_q, ur_q, lc_q;

  logic cmd_fire, out_fire, data_end, pad_end, underrun, in_body;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign data_end    = (cnt_q == len_q - 1'b1);
  assign pad_end     = (cnt_q == PadEnd);
  assign in_body     = (state_q == ST_DATA) || (state_q == ST_PAD);
  assign underrun    = (state_q == ST_DATA) && !late_col_i && out_ready_i && !in_valid_i;

  always_comb begin
    out_valid_o = 1'b0;
    out_last_o  = 1'b0;
    out_sel_o   = SEL_DATA;
    in_ready_o  = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        out_valid_o = in_valid_i && !late_col_i;
        in_ready_o  = out_ready_i && !late_col_i;
        out_last_o  = data_end && !pad_need_q && crc_inh_q;
      end
      ST_PAD: begin
        out_valid_o = !late_col_i;
        out_sel_o   = SEL_ZERO;
        out_last_o  = pad_end && crc_inh_q;
      end
      ST_FCS: begin
        out_valid_o = 1'b1;
        out_sel_o   = SEL_FCS;
        out_last_o  = (fidx_q == FcsEnd);
      end
      default: ;
    endcase
  end

  assign out_fire   = out_valid_o && out_ready_i;
  assign crc_init_o = cmd_fire;
  assign crc_en_o   = out_fire && in_body;
  assign fcs_idx_o  = fidx_q;
  assign fcs_bad_o  = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      len_q      <= '0;
      cnt_q      <= '0;
      pad_need_q <= 1'b0;
      crc_inh_q  <= 1'b0;
      fidx_q     <= '0;
      abort_q    <= 1'b0;
      late_q     <= 1'b0;
      ok_q       <= 1'b0;
      len_err_q  <= 1'b0;
      ur_q       <= 1'b0;
      lc_q       <= 1'b0;
    end else begin
      ok_q      <= 1'b0;
      len_err_q <= 1'b0;
      ur_q      <= 1'b0;
      lc_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_fire) begin
            if (legal_i) begin
              state_q    <= ST_DATA;
              len_q      <= cmd_len_i;
              pad_need_q <= pad_need_i;
              crc_inh_q  <= cmd_crc_inh_i;
              cnt_q      <= '0;
              fidx_q     <= '0;
              abort_q    <= 1'b0;
              late_q     <= 1'b0;
            end else begin
              len_err_q <= 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (late_col_i) begin
            state_q <= ST_FCS;
            abort_q <= 1'b1;
            late_q  <= 1'b1;
          end else if (underrun) begin
            state_q <= ST_FCS;
            abort_q <= 1'b1;
          end else if (out_fire) begin
            cnt_q <= cnt_q + 1'b1;
            if (data_end) begin
              if (pad_need_q)      state_q <= ST_PAD;
              else if (!crc_inh_q) state_q <= ST_FCS;
              else begin
                state_q <= ST_IDLE;
                ok_q    <= 1'b1;
              end
            end
          end
        end
        ST_PAD: begin
          if (late_col_i) begin
            state_q <= ST_FCS;
            abort_q <= 1'b1;
            late_q  <= 1'b1;
          end else if (out_fire) begin
            cnt_q <= cnt_q + 1'b1;
            if (pad_end) begin
              if (!crc_inh_q) state_q <= ST_FCS;
              else begin
                state_q <= ST_IDLE;
                ok_q    <= 1'b1;
              end
            end
          end
        end
        ST_FCS: begin
          if (out_fire) begin
            fidx_q <= fidx_q + 1'b1;
            if (fidx_q == FcsEnd) begin
              state_q <= ST_IDLE;
              ok_q    <= !abort_q;
              ur_q    <= abort_q && !late_q;
              lc_q    <= abort_q && late_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sts_ok_o       = ok_q;
  assign sts_len_err_o  = len_err_q;
  assign sts_underrun_o = ur_q;
  assign sts_late_col_o = lc_q;

  AST_LEN_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire && !legal_i |=> state_q == ST_IDLE); // R1

  AST_DATA_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> cnt_q < len_q); // R2

  AST_PAD_REACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FCS && pad_need_q && !abort_q |-> cnt_q == LEN_W'(PAD_MIN)); // R3

  AST_NO_FCS_INH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FCS |-> !crc_inh_q || abort_q); // R6

  AST_LATE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_body && late_col_i |=> state_q == ST_FCS && abort_q); // R9

  AST_END_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && out_last_o |=> $countones({ok_q, ur_q, lc_q}) == 1); // R10

  AST_ONE_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_q, len_err_q, ur_q, lc_q})); // R10
endmodule

// File: rtl/tx_fcs_framer.sv
module tx_fcs_framer
  import tx_fcs_pkg::*;
#(
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned MIN_LEN = 3,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned PAD_MIN = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             cmd_pad_en_i,
  input  logic             cmd_crc_inh_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  input  logic             late_col_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  output logic             sts_ok_o,
  output logic             sts_len_err_o,
  output logic             sts_underrun_o,
  output logic             sts_late_col_o
);
  logic        legal, pad_need, crc_init, crc_en, fcs_bad;
  logic [1:0]  fcs_idx;
  logic [31:0] crc;
  out_sel_e    out_sel;

  tx_len_check #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .PAD_MIN(PAD_MIN)) u_len (
    .len_i(cmd_len_i), .pad_en_i(cmd_pad_en_i), .legal_o(legal), .pad_need_o(pad_need)
  );

  tx_frame_seq #(.LEN_W(LEN_W), .PAD_MIN(PAD_MIN)) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_len_i, .cmd_crc_inh_i,
    .legal_i(legal), .pad_need_i(pad_need),
    .in_valid_i, .in_ready_o, .late_col_i,
    .out_valid_o, .out_ready_i, .out_last_o,
    .out_sel_o(out_sel), .fcs_idx_o(fcs_idx), .fcs_bad_o(fcs_bad),
    .crc_init_o(crc_init), .crc_en_o(crc_en),
    .sts_ok_o, .sts_len_err_o, .sts_underrun_o, .sts_late_col_o
  );

  tx_crc32 u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(crc_en), .data_i(out_data_o), .crc_o(crc)
  );

  tx_out_mux u_mux (
    .sel_i(out_sel), .in_data_i, .crc_i(crc), .idx_i(fcs_idx), .bad_i(fcs_bad), .data_o(out_data_o)
  );
endmodule

// File: tb/sim_tx_fcs_framer.sv
module sim_tx_fcs_framer;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, cmd_pad = 0, cmd_inh = 0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic in_valid = 0, in_ready, late_col = 0;
  logic [7:0] in_data = '0, out_data;
  logic out_valid, out_ready = 1, out_last;
  logic s_ok, s_len, s_ur, s_lc;

  int checks = 0, errors = 0;
  bit stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0] exp_q[$];
  string      exp_tag[$];
  logic [3:0] sts_q[$];
  string      sts_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_fcs_framer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_len_i(cmd_len),
    .cmd_pad_en_i(cmd_pad), .cmd_crc_inh_i(cmd_inh),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .late_col_i(late_col),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .sts_ok_o(s_ok), .sts_len_err_o(s_len), .sts_underrun_o(s_ur), .sts_late_col_o(s_lc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #(CLK_PERIOD/2 - 1);
      if (rst_n) begin
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(0, "R2 unexpected output byte", {23'd0, out_last, out_data}, 0);
          else begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            chk({out_last, out_data} == e, t, {23'd0, out_last, out_data}, {23'd0, e});
          end
        end
        if ({s_lc, s_ur, s_len, s_ok} != 4'b0) begin
          if (sts_q.size() == 0) chk(0, "R10 unexpected status", {s_lc, s_ur, s_len, s_ok}, 0);
          else begin
            logic [3:0] e;
            string t;
            e = sts_q.pop_front();
            t = sts_tag.pop_front();
            chk({s_lc, s_ur, s_len, s_ok} == e, t, {s_lc, s_ur, s_len, s_ok}, e);
          end
        end
      end
    end
  end

  // called at a negedge; returns at the negedge after the byte is taken
  task automatic put(input logic [7:0] d);
    bit f;
    in_data = d;
    in_valid = 1;
    f = 0;
    while (!f) begin
      #(CLK_PERIOD/2 - 1);
      f = in_ready;
      @(negedge clk);
    end
  endtask

  // mode 0 normal, 1 underrun after k bytes, 2 late col after k data bytes, 3 late col after k pad bytes
  task automatic run_frame(input int len, input bit pad, input bit inh, input int mode,
                           input int k, input int seed, input string tag);
    logic [7:0] b[$];
    logic [7:0] s[$];
    logic [31:0] c;
    int nsend;
    bit f;
    bit legal;
    for (int i = 0; i < len; i++) b.push_back(8'((i * 7 + seed) & 8'hFF));
    legal = (len >= 3) && (len <= 1518);
    @(negedge clk);
    cmd_len = LEN_W'(len);
    cmd_pad = pad;
    cmd_inh = inh;
    cmd_valid = 1;
    if (!legal) begin
      sts_q.push_back(4'b0010); sts_tag.push_back({tag, " R1 length error status"});
      in_valid = 1; in_data = 8'hAA;
      f = 0;
      while (!f) begin #(CLK_PERIOD/2 - 1); f = cmd_ready; @(negedge clk); end
      cmd_valid = 0;
      for (int i = 0; i < 4; i++) begin
        #(CLK_PERIOD/2 - 1);
        chk(in_ready == 1'b0, {tag, " R1 no input consumed"}, in_ready, 0);
        @(negedge clk);
      end
      in_valid = 0;
      repeat (2) @(negedge clk);
      return;
    end
    nsend = (mode == 1 || mode == 2) ? k : len;
    for (int i = 0; i < nsend; i++) s.push_back(b[i]);
    if (mode == 0 && pad) while (s.size() < 60) s.push_back(8'h00);
    if (mode == 3) for (int i = 0; i < k; i++) s.push_back(8'h00);
    c = 32'hFFFFFFFF;
    foreach (s[i]) c = ref_crc(c, s[i]);
    if (mode == 0 && inh) begin
      foreach (s[i]) begin
        exp_q.push_back({(i == s.size() - 1), s[i]});
        exp_tag.push_back({tag, " R2/R3/R5/R7 byte"});
      end
    end else begin
      foreach (s[i]) begin exp_q.push_back({1'b0, s[i]}); exp_tag.push_back({tag, " R2/R3/R4 byte"}); end
      if (mode == 0) c = ~c;
      for (int i = 0; i < 4; i++) begin
        exp_q.push_back({(i == 3), c[8*i +: 8]});
        exp_tag.push_back({tag, (mode == 0) ? " R6 FCS byte" : " R8/R9 bad FCS byte"});
      end
    end
    case (mode)
      0: begin sts_q.push_back(4'b0001); sts_tag.push_back({tag, " R10 ok status"}); end
      1: begin sts_q.push_back(4'b0100); sts_tag.push_back({tag, " R8 underrun status"}); end
      default: begin sts_q.push_back(4'b1000); sts_tag.push_back({tag, " R9 late collision status"}); end
    endcase
    in_valid = (nsend > 0);
    if (nsend > 0) in_data = b[0];
    f = 0;
    while (!f) begin #(CLK_PERIOD/2 - 1); f = cmd_ready; @(negedge clk); end
    cmd_valid = 0;
    for (int i = 0; i < nsend; i++) put(b[i]);
    in_valid = 0;
    if (mode == 2) begin
      in_valid = 1; in_data = b[k]; late_col = 1;
      @(negedge clk);
      late_col = 0; in_valid = 0;
    end else if (mode == 3) begin
      repeat (k) @(negedge clk);
      late_col = 1;
      @(negedge clk);
      late_col = 0;
    end
    while (!(cmd_ready && exp_q.size() == 0 && sts_q.size() == 0)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #(CLK_PERIOD/2 - 1);
    chk(cmd_ready == 1'b1, "R11 cmd_ready after reset", cmd_ready, 1);
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R11 in_ready after reset", in_ready, 0);
    chk({s_lc, s_ur, s_len, s_ok} == 4'b0, "R11 status after reset", {s_lc, s_ur, s_len, s_ok}, 0);
    stall_en = 1;
    run_frame(64, 1, 0, 0, 0, 3, "R2 R6 len64");
    run_frame(3, 1, 0, 0, 0, 9, "R3 len3 pad");
    run_frame(59, 1, 0, 0, 0, 1, "R3 len59 pad");
    run_frame(60, 1, 0, 0, 0, 5, "R3 len60 nopad");
    run_frame(10, 0, 0, 0, 0, 17, "R4 pad off");
    run_frame(10, 1, 1, 0, 0, 33, "R5 pad with inhibit");
    run_frame(20, 0, 1, 0, 0, 44, "R6 inhibit no pad");
    run_frame(2, 1, 0, 0, 0, 0, "R1 len2");
    run_frame(0, 1, 0, 0, 0, 0, "R1 len0");
    run_frame(1519, 1, 0, 0, 0, 0, "R1 len1519");
    run_frame(1518, 1, 0, 0, 0, 77, "R2 len1518");
    run_frame(30, 1, 0, 1, 5, 12, "R8 underrun k5");
    run_frame(30, 1, 1, 1, 0, 12, "R8 underrun inhibit k0");
    run_frame(40, 1, 0, 2, 7, 21, "R9 late col data");
    stall_en = 0;
    run_frame(10, 1, 0, 3, 4, 50, "R9 late col pad");
    run_frame(12, 1, 0, 0, 0, 66, "R7 back to back");
    chk(exp_q.size() == 0, "R10 byte queue drained", exp_q.size(), 0);
    chk(sts_q.size() == 0, "R10 status queue drained", sts_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule